// File: doc/BRIEF.md
# Converter Configuration and Power Sequencer

This block keeps the 24-bit configuration word of a delta-sigma converter and turns it into control outputs: the active power mode, a charge-pump drive disable, an oscillator enable, a ready flag and a conversion enable. A host-side front end supplies parallel write and read strobes. A selector on each strobe picks either the configuration word or an entry in one of three small calibration banks: offset, gain and channel setup.

Setting the self-reset bit starts a timed internal reset. When the reset finishes, the configuration word and all three banks return to their initial contents and a reset-valid flag goes high. While the self-reset bit is 1, the block refuses every change except to that bit. Reading the configuration word clears the reset-valid flag.

The power-save request bit and the power-save select bit choose between two idle states. Standby keeps the oscillator running, so the block is ready again as soon as the request is cleared. Sleep stops the oscillator. Leaving sleep starts a parameterised start-up wait, and the block is not ready until that wait ends.

Top module: `adc_cfg_ctrl`

## Requirements
- R1: After hardware reset, the configuration word reads 0x000040. Offset and channel-setup entries read 0x000000 and gain entries read 0x400000. `power_mode` is 0 (normal), `osc_en`=1, `ready`=1, `conv_en`=1 and `pump_off`=0.
- R2: With bit 7 clear in both the stored word and the written data, a configuration write (`wr_sel`=0) stores every bit of the data except bit 6. Bit 6 is the reset-valid flag, and host writes do not change it.
- R3: A configuration read (`rd_en` with `rd_sel`=0) returns the word with the current reset-valid bit 6 and clears bit 6 on the next clock edge.
- R4: A write that sets bit 7 (self-reset) starts a sequence that lasts `RST_CYCLES` clocks. At the end of the sequence the word becomes 0x000040 plus the current bit 7, and all bank entries return to their R1 values.
- R5: While bit 7 is 1, a configuration write changes only bit 7, and bank writes are ignored. Writing bit 7 back to 0 returns the block to normal operation.
- R6: `power_mode` is derived from bit 12 (power-save request), bit 11 (power-save select) and bit 8 (low power). With bit 12 = 0 the mode is 0 (normal) or 1 (low power, bit 8 = 1). With bit 12 = 1 the mode is 2 (standby, bit 11 = 0) or 3 (sleep, bit 11 = 1), and bit 8 has no effect.
- R7: In standby, `osc_en`=1 and `ready`=1. Clearing bit 12 restores `conv_en` in the cycle after the write.
- R8: In sleep, `osc_en`=0 and `ready`=0. After a write that leaves sleep, `osc_en` is 1, and `ready` and `conv_en` stay 0 for `WAKE_CYCLES` clocks before rising.
- R9: `pump_off` follows bit 9 of the configuration word.
- R10: Bank access uses `wr_sel`/`rd_sel` codes 1 (offset), 2 (gain) and 3 (channel setup), with the entry chosen by the index. Data written to an entry reads back unchanged.
- R11: `conv_en` is 1 only when `ready` is 1 and the mode is normal or low power.
- R12: `ready` is 0 while bit 7 is 1 or the reset sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 configuration, 1 offset, 2 gain, 3 channel setup |
| wr_idx | input | IDX_W | Bank entry for a write |
| wr_data | input | 24 | Write data |
| rd_en | input | 1 | Read strobe; clears the reset-valid flag when it targets the configuration word |
| rd_sel | input | 2 | Read target, coded as for `wr_sel` |
| rd_idx | input | IDX_W | Bank entry for a read |
| rd_data | output | 24 | Combinational read data for the current selection |
| power_mode | output | 2 | 0 normal, 1 low power, 2 standby, 3 sleep |
| pump_off | output | 1 | Charge-pump drive disable |
| osc_en | output | 1 | Oscillator enable |
| ready | output | 1 | Block settled and not in reset |
| conv_en | output | 1 | Conversions allowed |

## Verification
Every write and read strobe is captured on one clock edge. The results of a strobe — the stored word, the mode outputs and the cleared reset-valid flag — are visible from the next falling edge, so the bench drives inputs and samples outputs on falling edges. The two timed results are checked in the cycles on both sides of their due time. For the self-reset sequence, the bench samples `RST_CYCLES` falling edges after the write, where the old word must still show, and one edge later, where the initial word must show. For the sleep wake-up, it checks that `ready` is still low at `WAKE_CYCLES` falling edges after the write and high one edge later.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int WORD_W = 24;

    // Bit positions within the configuration word
    localparam int B_RV  = 6;
    localparam int B_RS  = 7;
    localparam int B_LP  = 8;
    localparam int B_PD  = 9;
    localparam int B_PSS = 11;
    localparam int B_PSR = 12;

    localparam logic [WORD_W-1:0] RV_MASK  = WORD_W'(1) << B_RV;
    localparam logic [WORD_W-1:0] RS_MASK  = WORD_W'(1) << B_RS;
    localparam logic [WORD_W-1:0] CFG_INIT = 24'h000040;

    localparam int NUM_BANKS = 3;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_LOWPWR  = 2'd1,
        PM_STANDBY = 2'd2,
        PM_SLEEP   = 2'd3
    } pwr_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_OFFSET = 2'd1,
        SEL_GAIN   = 2'd2,
        SEL_CHAN   = 2'd3
    } reg_sel_e;

    // Initial contents of bank b (0 offset, 1 gain, 2 channel setup)
    function automatic logic [WORD_W-1:0] bank_init(input int b);
        return (b == 1) ? 24'h400000 : 24'h000000;
    endfunction

    function automatic pwr_mode_e decode_mode(input logic [WORD_W-1:0] w);
        if (w[B_PSR]) return w[B_PSS] ? PM_SLEEP : PM_STANDBY;
        return w[B_LP] ? PM_LOWPWR : PM_NORMAL;
    endfunction

endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = (N > 1) ? $clog2(N + 1) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(N - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign last = st_q.busy && (st_q.cnt == '0);

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int          DEPTH = 4,
    parameter int          IDX_W = 2,
    parameter logic [23:0] INIT  = 24'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [23:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [23:0]      rd_data
);
    logic [23:0] mem_d [DEPTH];
    logic [23:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (init) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = INIT;
        end else if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
    import adc_cfg_pkg::*;
#(
    parameter  int RST_CYCLES  = 16,
    parameter  int WAKE_CYCLES = 50000,
    parameter  int BANK_DEPTH  = 4,
    localparam int IDX_W       = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        power_mode,
    output logic              pump_off,
    output logic              osc_en,
    output logic              ready,
    output logic              conv_en
);
    typedef struct packed {
        logic [WORD_W-1:0] cfg;
    } ctrl_t;

    ctrl_t       st_d, st_q;
    logic        wr_cfg;
    logic        rst_start, rst_busy, rst_last;
    logic        wake_start, wake_busy, wake_last;
    pwr_mode_e   mode_q, mode_d;
    logic [WORD_W-1:0] cfg_word;
    logic [WORD_W-1:0] bank_rd [NUM_BANKS];

    // Next-state computation
    always_comb begin
        st_d   = st_q;
        wr_cfg = wr_en && (wr_sel == SEL_CFG);
        if (wr_cfg) begin
            if (st_q.cfg[B_RS] || wr_data[B_RS]) begin
                st_d.cfg[B_RS] = wr_data[B_RS];
            end else begin
                st_d.cfg = (wr_data & ~RV_MASK) | (st_q.cfg & RV_MASK);
            end
        end
        if (rd_en && (rd_sel == SEL_CFG)) st_d.cfg[B_RV] = 1'b0;
        if (rst_last) st_d.cfg = CFG_INIT | (st_d.cfg & RS_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cfg <= CFG_INIT;
        else        st_q     <= st_d;
    end

    assign cfg_word   = st_q.cfg;
    assign rst_start  = wr_cfg && !st_q.cfg[B_RS] && wr_data[B_RS];
    assign mode_q     = decode_mode(st_q.cfg);
    assign mode_d     = decode_mode(st_d.cfg);
    assign wake_start = (mode_q == PM_SLEEP) && (mode_d != PM_SLEEP);

    cfg_timer #(.N(RST_CYCLES)) u_rst_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (rst_busy),
        .last  (rst_last)
    );

    cfg_timer #(.N(WAKE_CYCLES)) u_wake_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_start),
        .busy  (wake_busy),
        .last  (wake_last)
    );

    // Offset, gain and channel-setup banks
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_sel == 2'(b + 1)) && !st_q.cfg[B_RS];
        cfg_bank #(
            .DEPTH (BANK_DEPTH),
            .IDX_W (IDX_W),
            .INIT  (bank_init(b))
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (rst_last),
            .wr_en   (bank_we),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_idx  (rd_idx),
            .rd_data (bank_rd[b])
        );
    end

    always_comb begin
        case (rd_sel)
            SEL_OFFSET: rd_data = bank_rd[0];
            SEL_GAIN:   rd_data = bank_rd[1];
            SEL_CHAN:   rd_data = bank_rd[2];
            default:    rd_data = st_q.cfg;
        endcase
    end

    assign power_mode = mode_q;
    assign pump_off   = st_q.cfg[B_PD];
    assign osc_en     = (mode_q != PM_SLEEP);
    assign ready      = !st_q.cfg[B_RS] && !rst_busy && !wake_busy
                        && (mode_q != PM_SLEEP);
    assign conv_en    = ready && ((mode_q == PM_NORMAL) || (mode_q == PM_LOWPWR));

    logic unused_ok;
    assign unused_ok = wake_last;

endmodule

// File: rtl/adc_cfg_ctrl_chk.sv
module adc_cfg_ctrl_chk
    import adc_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              rd_en,
    input logic [1:0]        rd_sel,
    input logic [WORD_W-1:0] cfg_word,
    input logic              rst_last,
    input logic [1:0]        power_mode,
    input logic              osc_en,
    input logic              ready,
    input logic              conv_en
);
    localparam logic [WORD_W-1:0] KEEP_MASK = ~(RS_MASK | RV_MASK);

    // R3: a configuration read clears the reset-valid flag
    p_rv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd0 && !rst_last) |=> !cfg_word[B_RV]);

    // R4: the end of the reset sequence raises the reset-valid flag
    p_rv_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_last |=> cfg_word[B_RV]);

    // R5: with self-reset held, a write changes nothing but bit 7
    p_rs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[B_RS] && wr_en && wr_sel == 2'd0 && !rst_last)
        |=> (((cfg_word ^ $past(cfg_word)) & KEEP_MASK) == '0));

    // R8: sleep stops the oscillator and drops ready
    p_sleep_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (power_mode == 2'd3) |-> (!osc_en && !ready));

    // R8: an oscillator restart is never immediately ready
    p_wake_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !ready);

    // R11: conversions only when ready in an active mode
    p_conv_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> (ready && power_mode[1] == 1'b0));

endmodule

bind adc_cfg_ctrl adc_cfg_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .cfg_word   (cfg_word),
    .rst_last   (rst_last),
    .power_mode (power_mode),
    .osc_en     (osc_en),
    .ready      (ready),
    .conv_en    (conv_en)
);

// File: tb/adc_cfg_ctrl_bench.sv
module adc_cfg_ctrl_bench;

    localparam int RST_N_CYC  = 4;
    localparam int WAKE_N_CYC = 10;
    localparam int DEPTH      = 4;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [23:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_sel = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [23:0]   rd_data;
    logic [1:0]    power_mode;
    logic          pump_off, osc_en, ready, conv_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_cfg_ctrl #(
        .RST_CYCLES  (RST_N_CYC),
        .WAKE_CYCLES (WAKE_N_CYC),
        .BANK_DEPTH  (DEPTH)
    ) u_adc_cfg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .power_mode(power_mode), .pump_off(pump_off), .osc_en(osc_en),
        .ready(ready), .conv_en(conv_en)
    );

    // {wdata[23:0], mode[1:0], pump, osc, ready, conv}
    localparam logic [29:0] VEC [8] = '{
        {24'h000000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        {24'h000100, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1},
        {24'h000200, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        {24'h001000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
        {24'h001100, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
        {24'h000300, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1},
        {24'h000800, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        {24'h000000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_write(input logic [1:0] sel, input logic [IW-1:0] idx, input logic [23:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, input logic [IW-1:0] idx, output logic [23:0] d);
        rd_sel = sel; rd_idx = idx;
        #1 d = rd_data;
    endtask

    task automatic do_read(input logic [1:0] sel, input logic [IW-1:0] idx, output logic [23:0] d);
        rd_en = 1'b1; rd_sel = sel; rd_idx = idx;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, '0, v);  check("R1 cfg", v, 24'h000040);
        peek(2'd1, 2'd2, v); check("R1 offset", v, 24'h000000);
        peek(2'd2, 2'd3, v); check("R1 gain", v, 24'h400000);
        peek(2'd3, 2'd0, v); check("R1 chan", v, 24'h000000);
        check("R1 outs", {power_mode, osc_en, ready, conv_en, pump_off}, {2'd0, 4'b1110});

        // R3 read returns then clears reset-valid
        do_read(2'd0, '0, v); check("R3 first read", v, 24'h000040);
        do_read(2'd0, '0, v); check("R3 second read", v, 24'h000000);

        // R6 R7 R9 R11 vector walk
        for (int i = 0; i < 8; i++) begin
            do_write(2'd0, '0, VEC[i][29:6]);
            peek(2'd0, '0, v);
            check("R2 readback", v, VEC[i][29:6]);
            check("R6 R9 R11 outs", {power_mode, pump_off, osc_en, ready, conv_en}, VEC[i][5:0]);
        end

        // R2 bit 6 is read-only
        do_write(2'd0, '0, 24'h0A0041);
        peek(2'd0, '0, v); check("R2 rv ignored", v, 24'h0A0001);

        // R10 bank access
        do_write(2'd1, 2'd1, 24'h123456);
        do_write(2'd2, 2'd3, 24'h0ABCDE);
        do_write(2'd3, 2'd0, 24'h00F00F);
        peek(2'd1, 2'd1, v); check("R10 offset", v, 24'h123456);
        peek(2'd2, 2'd3, v); check("R10 gain", v, 24'h0ABCDE);
        peek(2'd3, 2'd0, v); check("R10 chan", v, 24'h00F00F);
        peek(2'd1, 2'd0, v); check("R10 other entry", v, 24'h000000);

        // R4 R12 self-reset sequence
        do_write(2'd0, '0, 24'h000080);
        check("R12 ready low", {23'd0, ready}, 32'd0);
        repeat (RST_N_CYC - 1) @(negedge clk);
        peek(2'd0, '0, v); check("R4 before end", v, 24'h0A0081);
        @(negedge clk);
        peek(2'd0, '0, v); check("R4 init word", v, 24'h0000C0);
        peek(2'd1, 2'd1, v); check("R4 offset init", v, 24'h000000);
        peek(2'd2, 2'd3, v); check("R4 gain init", v, 24'h400000);
        check("R12 ready held", {23'd0, ready}, 32'd0);

        // R5 lockout while bit 7 set
        do_write(2'd0, '0, 24'h001380);
        peek(2'd0, '0, v); check("R5 cfg locked", v, 24'h0000C0);
        check("R5 pump unchanged", {31'd0, pump_off}, 32'd0);
        do_write(2'd2, 2'd0, 24'h111111);
        peek(2'd2, 2'd0, v); check("R5 bank locked", v, 24'h400000);
        do_write(2'd0, '0, 24'h001300);
        peek(2'd0, '0, v); check("R5 only rs clears", v, 24'h000040);
        check("R12 ready back", {31'd0, ready}, 32'd1);
        do_write(2'd0, '0, 24'h000200);
        check("R9 pump", {31'd0, pump_off}, 32'd1);

        // R7 standby return is immediate
        do_write(2'd0, '0, 24'h001000);
        check("R7 standby", {power_mode, osc_en, ready, conv_en}, {2'd2, 3'b110});
        do_write(2'd0, '0, 24'h000000);
        check("R7 return", {power_mode, osc_en, ready, conv_en}, {2'd0, 3'b111});

        // R8 sleep and timed wake
        do_write(2'd0, '0, 24'h001800);
        check("R8 sleep", {power_mode, osc_en, ready, conv_en}, {2'd3, 3'b000});
        do_write(2'd0, '0, 24'h000100);
        check("R8 wake start", {power_mode, osc_en, ready, conv_en}, {2'd1, 3'b100});
        repeat (WAKE_N_CYC - 1) @(negedge clk);
        check("R8 wake last", {osc_en, ready, conv_en}, 3'b100);
        @(negedge clk);
        check("R8 wake done", {osc_en, ready, conv_en}, 3'b111);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule